// File: doc/BRIEF.md
# Dual-Mode Digital Phase Detector

This block measures the phase relation between two square waves, a reference and a feedback signal, inside a synchronous design. Each input is first brought into the system clock domain through a short flip-flop chain and then searched for rising edges. Two phase-error pulse trains are produced side by side. One is the exclusive-OR of the two input levels. The other is a latch that a reference rising edge sets and a feedback rising edge clears.

The averages of these pulse trains follow the phase difference, and a downstream loop filter uses that average. The XOR train covers 0 to 180 degrees. It needs 50% duty inputs to reach its full range, its ripple is at twice the input frequency, and it locks at 90 degrees with a half-scale average. The latch train covers 0 to 360 degrees. It responds only to rising edges, so input duty does not matter. It locks at 180 degrees, its ripple is at the input frequency, and it falls to zero when no reference is present. A registered select input chooses which of the two trains drives a shared output.

Top module: `phase_cmp_xs`

## Requirements
- R1: While `rst` is high at a clock edge, `xor_out`, `sr_out` and `pd_out` are 0 after that edge. The synchronisers and the edge history are cleared as well.
- R2: `xor_out` equals the exclusive-OR of `ref_in` and `fb_in` as sampled three clock edges earlier: two synchroniser stages plus one output register.
- R3: A rising edge on `ref_in` makes `sr_out` 1 three clock edges after the new level is first sampled.
- R4: A rising edge on `fb_in` makes `sr_out` 0 with the same three-edge latency, provided no reference rising edge is detected in the same cycle.
- R5: When reference and feedback rising edges are detected in the same clock cycle, the set wins and `sr_out` becomes 1.
- R6: Falling edges and steady levels on either input leave `sr_out` unchanged.
- R7: `pd_out` follows `xor_out` when the registered select is 0 and `sr_out` when it is 1. A change on `mode_sel` takes effect one clock edge after it is sampled.
- R8: With `ref_in` held low, each feedback rising edge drives `sr_out` to 0, and it stays at 0.
- R9: Take square waves of period 16 clocks at 50% duty, with feedback lagging the reference by 4 clocks (90 degrees). Over 32 clocks, `xor_out` is high for 16 clocks and `sr_out` is high for 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference square wave, asynchronous |
| fb_in | input | 1 | Feedback square wave, asynchronous |
| mode_sel | input | 1 | 0 selects the XOR train, 1 selects the latch train for `pd_out` |
| xor_out | output | 1 | XOR phase-error train |
| sr_out | output | 1 | Edge-latch phase-error train |
| pd_out | output | 1 | Selected phase-error train |

## Verification
The bench targets these corner cases:
- **Both edges in one cycle.** A design that lets the clear win would drop `sr_out` to 0 instead of setting it.
- **Falling edges.** A latch that reacts to levels or to both edge polarities would change `sr_out` when either input goes low.
- **Feedback-only stimulus.** A design that ignores the no-reference case would leave `sr_out` stuck at 1.
- **Select timing.** A design that reads `mode_sel` combinationally would switch `pd_out` one cycle early.

A 90-degree duty measurement checks both trains together. A wrong synchroniser depth or a mismatched delay between the two paths shows up as a wrong high count on one train.

// File: rtl/phase_cmp_xs.sv
module phase_cmp_xs #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  input  logic mode_sel,
  output logic xor_out,
  output logic sr_out,
  output logic pd_out
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] ref_sync, fb_sync;
  logic ref_prev, fb_prev;
  logic xor_q, sr_q, mode_q;

  wire ref_lvl  = ref_sync[LAST];
  wire fb_lvl   = fb_sync[LAST];
  wire ref_rise = ref_lvl & ~ref_prev;
  wire fb_rise  = fb_lvl & ~fb_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          ref_sync <= '0;
          fb_sync  <= '0;
        end else begin
          ref_sync <= ref_in;
          fb_sync  <= fb_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          ref_sync <= '0;
          fb_sync  <= '0;
        end else begin
          ref_sync <= {ref_sync[LAST-1:0], ref_in};
          fb_sync  <= {fb_sync[LAST-1:0], fb_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_prev <= 1'b0;
      fb_prev  <= 1'b0;
      xor_q    <= 1'b0;
      sr_q     <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      ref_prev <= ref_lvl;
      fb_prev  <= fb_lvl;
      xor_q    <= ref_lvl ^ fb_lvl;
      mode_q   <= mode_sel;
      if (ref_rise)     sr_q <= 1'b1;
      else if (fb_rise) sr_q <= 1'b0;
    end
  end

  assign xor_out = xor_q;
  assign sr_out  = sr_q;
  assign pd_out  = mode_q ? sr_q : xor_q;
endmodule

module phase_cmp_xs_chk (
  input logic clk,
  input logic rst,
  input logic ref_in,
  input logic fb_in,
  input logic mode_sel,
  input logic xor_out,
  input logic sr_out,
  input logic pd_out
);
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end
  wire warm = (age >= 3'd5);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!xor_out && !sr_out && !pd_out));

  a_r2_xor_levels: assert property (@(posedge clk) disable iff (rst)
    warm |-> (xor_out == ($past(ref_in, 3) ^ $past(fb_in, 3))));

  a_r3_r5_set_on_ref: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(ref_in, 3) && !$past(ref_in, 4)) |-> sr_out);

  a_r4_clear_on_fb: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(fb_in, 3) && !$past(fb_in, 4)
          && !($past(ref_in, 3) && !$past(ref_in, 4))) |-> !sr_out);

  a_r6_hold_no_edge: assert property (@(posedge clk) disable iff (rst)
    (warm && !($past(ref_in, 3) && !$past(ref_in, 4))
          && !($past(fb_in, 3) && !$past(fb_in, 4))) |-> $stable(sr_out));

  a_r7_select: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pd_out == ($past(mode_sel) ? sr_out : xor_out)));
endmodule

bind phase_cmp_xs phase_cmp_xs_chk u_chk (.*);

// File: tb/sim_phase_cmp_xs.sv
`timescale 1ns/1ps
module sim_phase_cmp_xs;
  logic clk = 1'b0;
  logic rst, ref_in, fb_in, mode_sel;
  logic xor_out, sr_out, pd_out;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  phase_cmp_xs u0 (.clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
                   .mode_sel(mode_sel), .xor_out(xor_out), .sr_out(sr_out),
                   .pd_out(pd_out));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; ref_in = 1'b1; fb_in = 1'b0; mode_sel = 1'b0;
    step(4);
    check("R1 xor_out", xor_out, 0);
    check("R1 sr_out", sr_out, 0);
    check("R1 pd_out", pd_out, 0);
    ref_in = 1'b0;
    rst = 1'b0;
    step(4);
  endtask

  task automatic t_xor;
    for (int k = 0; k < 4; k++) begin
      ref_in = k[1]; fb_in = k[0];
      step(3);
      check("R2 xor_out", xor_out, k[1] ^ k[0]);
    end
    ref_in = 1'b0; fb_in = 1'b0; step(4);
  endtask

  task automatic t_set_clear;
    ref_in = 1'b1; step(3);
    check("R3 set", sr_out, 1);
    fb_in = 1'b1; step(3);
    check("R4 clear", sr_out, 0);
  endtask

  task automatic t_simul;
    ref_in = 1'b0; fb_in = 1'b0; step(4);
    check("R5 pre", sr_out, 0);
    ref_in = 1'b1; fb_in = 1'b1; step(3);
    check("R5 set wins", sr_out, 1);
  endtask

  task automatic t_falling;
    ref_in = 1'b0; step(4);
    check("R6 ref fall", sr_out, 1);
    fb_in = 1'b0; step(4);
    check("R6 fb fall", sr_out, 1);
    fb_in = 1'b1; step(3);
    check("R6 fb rise after", sr_out, 0);
    fb_in = 1'b0; step(3);
  endtask

  task automatic t_mode;
    ref_in = 1'b1; step(3);
    fb_in = 1'b1; step(3);
    ref_in = 1'b0; step(3);
    check("R7 setup xor", xor_out, 1);
    check("R7 setup sr", sr_out, 0);
    check("R7 pd xor", pd_out, 1);
    mode_sel = 1'b1; step(1);
    check("R7 pd sr", pd_out, 0);
    mode_sel = 1'b0; step(1);
    check("R7 pd back", pd_out, 1);
    fb_in = 1'b0; step(4);
  endtask

  task automatic t_noref;
    ref_in = 1'b1; step(3);
    ref_in = 1'b0; step(3);
    check("R8 pre", sr_out, 1);
    for (int k = 0; k < 3; k++) begin
      fb_in = 1'b1; step(4);
      check("R8 no ref", sr_out, 0);
      fb_in = 1'b0; step(4);
      check("R8 no ref low", sr_out, 0);
    end
  endtask

  task automatic t_duty;
    int xh = 0, sh = 0;
    for (int i = 0; i < 96; i++) begin
      if (i >= 64) begin
        xh += xor_out;
        sh += sr_out;
      end
      ref_in = ((i % 16) < 8);
      fb_in  = (((i + 12) % 16) < 8);
      step(1);
    end
    check("R9 xor duty", xh, 16);
    check("R9 sr duty", sh, 8);
  endtask

  initial begin
    t_reset();
    t_xor();
    t_set_clear();
    t_simul();
    t_falling();
    t_mode();
    t_noref();
    t_duty();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule